// File: doc/BRIEF.md
# Register-Held Page Table Address Translator

This block turns a logical address into a physical address through a small page table kept entirely in flip-flops. The high bits of the logical address select a page, and the low bits are an offset within that page. The selected entry supplies a frame number. The physical address is that frame number scaled by the page size, plus the unchanged offset. Each entry also carries a valid flag and three permission flags, one each for read, write and instruction fetch. A separate table-length register caps the page numbers that may be used.

A request presents an address and an access kind. One clock later the block returns either the translated address or a fault with a cause code. When several faults apply, the block reports only the one with the highest priority. The table entries and the length register can be loaded through a write port. That port acts only when its privilege input is high. The default configuration uses a 16-bit logical address and 8 KB pages, which gives eight entries and a 19-bit physical address.

Top module: `pt_xlate`

## Requirements
- R1: The low PAGE_BITS bits of `req_vaddr` are the offset. The offset appears unchanged in the low bits of `rsp_paddr` on every translation that does not fault. The remaining high bits are the page number.
- R2: A request with `req_valid` high produces `rsp_valid` high exactly one clock later. A cycle with `req_valid` low produces `rsp_valid` low one clock later. On success, `rsp_paddr` equals frame × 2^PAGE_BITS + offset (for example, page 0 mapped to frame 5 with offset 3 gives 40963).
- R3: A page number greater than or equal to the table-length register value faults with cause 1.
- R4: A page number within the length whose entry has its valid flag clear faults with cause 2.
- R5: Permission flags are bit 0 read, bit 1 write and bit 2 fetch. Access kind 0 is read, 1 is write and 2 is fetch; each is allowed only when its flag is set. Kind 3 always faults. A disallowed access faults with cause 3.
- R6: Fault priority is length (1) first, then invalid (2), then protection (3). Cause 0 means success.
- R7: Whenever the reported cause is not 0, `rsp_paddr` is zero.
- R8: Entry writes (`ent_we`) and length writes (`len_we`) take effect at the next clock edge only if `cfg_priv` is high. Without it they change nothing.
- R9: After reset, every entry is invalid, the length is 0 and `rsp_valid` is low. Any request made after reset therefore faults with cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VADDR_W | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| cfg_priv | input | 1 | Privilege qualifier for both write ports |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | VADDR_W-PAGE_BITS | Entry index to write |
| ent_frame | input | FRAME_W | Frame number to store |
| ent_valid | input | 1 | Valid flag to store |
| ent_perm | input | 3 | Permission flags to store ({fetch, write, read}) |
| len_we | input | 1 | Length register write strobe |
| len_val | input | VADDR_W-PAGE_BITS+1 | New table length |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | FRAME_W+PAGE_BITS | Physical address, zero on fault |
| rsp_fault | output | 2 | Fault cause: 0 none, 1 length, 2 invalid, 3 protection |

## Verification
The table is loaded with a mix of frames and permissions, including an entry with no permissions, an entry mapped to frame 0 and an entry mapped to the top frame. Each entry is then accessed with every kind of access. Offsets of zero, three and all-ones show that the offset bits pass through and do not mix with the frame field. Pages that are both beyond the length and invalid, and pages that are invalid and also lack a permission, show which fault cause wins when several apply. Unprivileged writes are followed by accesses that would translate differently had the write taken effect. A later privileged length increase then shows that the previously out-of-range pages become reachable.

// File: rtl/pt_pkg.sv
package pt_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_LEN     = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_PROT    = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int PERM_W = 3;

endpackage

// File: rtl/pt_table.sv
module pt_table #(
   parameter int PN_W    = 3,
   parameter int FRAME_W = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_priv,
   input  logic                       ent_we,
   input  logic [PN_W-1:0]            ent_idx,
   input  logic [FRAME_W-1:0]         ent_frame,
   input  logic                       ent_valid,
   input  logic [pt_pkg::PERM_W-1:0]  ent_perm,
   input  logic                       len_we,
   input  logic [PN_W:0]              len_val,
   input  logic [PN_W-1:0]            rd_idx,
   output logic [FRAME_W-1:0]         rd_frame,
   output logic                       rd_valid,
   output logic [pt_pkg::PERM_W-1:0]  rd_perm,
   output logic [PN_W:0]              len_o
);
   localparam int ENTRIES = 1 << PN_W;

   logic [FRAME_W-1:0]        frame_q [ENTRIES];
   logic                      valid_q [ENTRIES];
   logic [pt_pkg::PERM_W-1:0] perm_q  [ENTRIES];
   logic [PN_W:0]             len_q;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               frame_q[g] <= '0;
               valid_q[g] <= 1'b0;
               perm_q[g]  <= '0;
            end else if (ent_we && wr_priv && (ent_idx == PN_W'(g))) begin
               frame_q[g] <= ent_frame;
               valid_q[g] <= ent_valid;
               perm_q[g]  <= ent_perm;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                len_q <= '0;
      else if (len_we && wr_priv) len_q <= len_val;
   end

   assign rd_frame = frame_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];
   assign rd_perm  = perm_q[rd_idx];
   assign len_o    = len_q;

   // R8: an unprivileged length write leaves the length untouched
   assert_unpriv_len_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (len_we && !wr_priv) |=> $stable(len_q));

   // R8: an unprivileged entry write leaves the addressed valid flag untouched
   assert_unpriv_ent_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we && !wr_priv && !len_we && rd_idx == ent_idx) |=> $stable(rd_valid));

endmodule

// File: rtl/pt_check.sv
module pt_check #(
   parameter int PN_W = 3
) (
   input  logic [PN_W-1:0]            page,
   input  logic [PN_W:0]              len,
   input  logic                       ent_valid,
   input  logic [pt_pkg::PERM_W-1:0]  ent_perm,
   input  logic [1:0]                 kind,
   output pt_pkg::fault_e             fault
);
   import pt_pkg::*;

   logic in_range;
   logic allowed;

   assign in_range = ({1'b0, page} < len);

   always_comb begin
      case (acc_e'(kind))
         ACC_READ:  allowed = ent_perm[0];
         ACC_WRITE: allowed = ent_perm[1];
         ACC_EXEC:  allowed = ent_perm[2];
         default:   allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (!in_range)       fault = FLT_LEN;
      else if (!ent_valid) fault = FLT_INVALID;
      else if (!allowed)   fault = FLT_PROT;
      else                 fault = FLT_NONE;
   end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
   parameter int VADDR_W   = 16,
   parameter int PAGE_BITS = 13,
   parameter int FRAME_W   = 6,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [VADDR_W-1:0]             req_vaddr,
   input  logic [1:0]                     req_kind,
   input  logic                           cfg_priv,
   input  logic                           ent_we,
   input  logic [VADDR_W-PAGE_BITS-1:0]   ent_idx,
   input  logic [FRAME_W-1:0]             ent_frame,
   input  logic                           ent_valid,
   input  logic [2:0]                     ent_perm,
   input  logic                           len_we,
   input  logic [VADDR_W-PAGE_BITS:0]     len_val,
   output logic                           rsp_valid,
   output logic [FRAME_W+PAGE_BITS-1:0]   rsp_paddr,
   output logic [1:0]                     rsp_fault
);
   import pt_pkg::*;

   localparam int PN_W    = VADDR_W - PAGE_BITS;
   localparam int PADDR_W = FRAME_W + PAGE_BITS;

   generate
      if (PAGE_BITS < 1 || PAGE_BITS >= VADDR_W) begin : g_bad_split
         $error("pt_xlate: PAGE_BITS must lie between 1 and VADDR_W-1");
      end
      if (PN_W > 8) begin : g_bad_depth
         $error("pt_xlate: page table too deep to hold in registers");
      end
      if (FRAME_W < 1) begin : g_bad_frame
         $error("pt_xlate: FRAME_W must be positive");
      end
   endgenerate

   logic [PN_W-1:0]      page;
   logic [PAGE_BITS-1:0] offset;
   logic [FRAME_W-1:0]   frame;
   logic                 e_valid;
   logic [PERM_W-1:0]    e_perm;
   logic [PN_W:0]        len_cur;
   fault_e               fault_c;
   logic [PADDR_W-1:0]   paddr_c;

   assign page   = req_vaddr[VADDR_W-1:PAGE_BITS];
   assign offset = req_vaddr[PAGE_BITS-1:0];

   pt_table #(.PN_W(PN_W), .FRAME_W(FRAME_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_priv   (cfg_priv),
      .ent_we    (ent_we),
      .ent_idx   (ent_idx),
      .ent_frame (ent_frame),
      .ent_valid (ent_valid),
      .ent_perm  (ent_perm),
      .len_we    (len_we),
      .len_val   (len_val),
      .rd_idx    (page),
      .rd_frame  (frame),
      .rd_valid  (e_valid),
      .rd_perm   (e_perm),
      .len_o     (len_cur)
   );

   pt_check #(.PN_W(PN_W)) u_check (
      .page      (page),
      .len       (len_cur),
      .ent_valid (e_valid),
      .ent_perm  (e_perm),
      .kind      (req_kind),
      .fault     (fault_c)
   );

   assign paddr_c = (fault_c == FLT_NONE) ? {frame, offset} : '0;

   generate
      if (OUT_REG) begin : g_reg
         logic               v_q;
         logic [PADDR_W-1:0] pa_q;
         logic [1:0]         f_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q  <= 1'b0;
               pa_q <= '0;
               f_q  <= FLT_NONE;
            end else begin
               v_q  <= req_valid;
               pa_q <= req_valid ? paddr_c : '0;
               f_q  <= req_valid ? fault_c : FLT_NONE;
            end
         end

         assign rsp_valid = v_q;
         assign rsp_paddr = pa_q;
         assign rsp_fault = f_q;

         // R2: one-cycle response latency
         assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> rsp_valid);
         assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !rsp_valid);
         // R1: offset is carried through untouched on success
         assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> (rsp_fault != FLT_NONE ||
                           rsp_paddr[PAGE_BITS-1:0] == $past(offset)));
         // R3: out-of-range page reports the length cause
         assert_len_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && ({1'b0, page} >= len_cur)) |=> (rsp_fault == FLT_LEN));
         // R4: in-range invalid entry reports the invalid cause
         assert_invalid_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && ({1'b0, page} < len_cur) && !e_valid) |=> (rsp_fault == FLT_INVALID));
         // R7: faulting responses carry a zero address
         assert_zero_addr_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
      end else begin : g_comb
         assign rsp_valid = req_valid;
         assign rsp_paddr = req_valid ? paddr_c : '0;
         assign rsp_fault = req_valid ? fault_c : FLT_NONE;
      end
   endgenerate

endmodule

// File: tb/pt_xlate_tb.sv
module pt_xlate_tb;

   localparam int VADDR_W   = 16;
   localparam int PAGE_BITS = 13;
   localparam int FRAME_W   = 6;
   localparam int PN_W      = VADDR_W - PAGE_BITS;
   localparam int PADDR_W   = FRAME_W + PAGE_BITS;
   localparam int NVEC      = 14;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [VADDR_W-1:0] req_vaddr = '0;
   logic [1:0]         req_kind = '0;
   logic               cfg_priv = 1'b0;
   logic               ent_we = 1'b0;
   logic [PN_W-1:0]    ent_idx = '0;
   logic [FRAME_W-1:0] ent_frame = '0;
   logic               ent_valid = 1'b0;
   logic [2:0]         ent_perm = '0;
   logic               len_we = 1'b0;
   logic [PN_W:0]      len_val = '0;
   logic               rsp_valid;
   logic [PADDR_W-1:0] rsp_paddr;
   logic [1:0]         rsp_fault;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   pt_xlate #(.VADDR_W(VADDR_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .cfg_priv(cfg_priv), .ent_we(ent_we), .ent_idx(ent_idx),
      .ent_frame(ent_frame), .ent_valid(ent_valid), .ent_perm(ent_perm),
      .len_we(len_we), .len_val(len_val), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
   );

   // address, kind, expected physical address, expected cause
   localparam logic [15:0] V_ADDR [NVEC] = '{
      16'h0000, 16'h0003, 16'h1FFF, 16'h2000, 16'h2100, 16'h2000, 16'h40AB,
      16'h4000, 16'h6000, 16'h9FFF, 16'hA000, 16'hC000, 16'hE000, 16'h8000};
   localparam logic [1:0] V_KIND [NVEC] = '{
      2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd2, 2'd2,
      2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd1, 2'd3};
   localparam int V_PA [NVEC] = '{
      40960, 40963, 0, 49152, 49408, 0, 171,
      0, 0, 524287, 0, 0, 0, 0};
   localparam logic [1:0] V_FLT [NVEC] = '{
      2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd3, 2'd0,
      2'd3, 2'd2, 2'd0, 2'd3, 2'd1, 2'd1, 2'd3};
   localparam string V_TAG [NVEC] = '{
      "R2", "R1", "R5", "R2", "R1", "R5", "R1",
      "R5", "R4", "R1", "R5", "R3", "R6", "R5"};

   task automatic check(input string tag, input int got, input int exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr_entry(input int idx, input int frame, input bit v,
                           input int perm, input bit priv);
      @(negedge clk);
      ent_we = 1'b1; cfg_priv = priv; ent_idx = PN_W'(idx);
      ent_frame = FRAME_W'(frame); ent_valid = v; ent_perm = 3'(perm);
      @(negedge clk);
      ent_we = 1'b0; cfg_priv = 1'b0;
   endtask

   task automatic wr_len(input int len, input bit priv);
      @(negedge clk);
      len_we = 1'b1; cfg_priv = priv; len_val = (PN_W+1)'(len);
      @(negedge clk);
      len_we = 1'b0; cfg_priv = 1'b0;
   endtask

   task automatic access(input string tag, input int addr, input int kind,
                         input int exp_pa, input int exp_flt);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = VADDR_W'(addr); req_kind = 2'(kind);
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, int'(rsp_valid), 1);
      check(tag, int'(rsp_paddr), exp_pa);
      check(tag, int'(rsp_fault), exp_flt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", int'(rsp_valid), 0);
      access("R9", 16'h0000, 0, 0, 1);
      // R2: idle cycle yields no response
      @(negedge clk);
      check("R2", int'(rsp_valid), 0);

      wr_entry(0, 5, 1, 3'b001, 1);
      wr_entry(1, 6, 1, 3'b011, 1);
      wr_entry(2, 0, 1, 3'b100, 1);
      wr_entry(3, 9, 0, 3'b111, 1);
      wr_entry(4, 63, 1, 3'b111, 1);
      wr_entry(5, 1, 1, 3'b000, 1);
      wr_entry(6, 7, 1, 3'b111, 1);
      wr_entry(7, 2, 0, 3'b000, 1);
      wr_len(6, 1);

      for (int i = 0; i < NVEC; i++)
         access(V_TAG[i], int'(V_ADDR[i]), int'(V_KIND[i]), V_PA[i], int'(V_FLT[i]));

      // R8: unprivileged entry write is ignored
      wr_entry(3, 4, 1, 3'b111, 0);
      access("R8", 16'h6000, 0, 0, 2);
      // R8: unprivileged length write is ignored
      wr_len(8, 0);
      access("R8", 16'hC000, 0, 0, 1);
      // privileged length raise opens pages 6 and 7
      wr_len(8, 1);
      access("R3", 16'hC000, 0, 57344, 0);
      // R6: page 7 now in range, invalid wins over missing permission
      access("R6", 16'hE000, 1, 0, 2);
      // R6: valid entry lacking permission yields protection
      access("R6", 16'hA005, 2, 0, 3);
      // back-to-back requests
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 16'h0007; req_kind = 2'd0;
      @(negedge clk);
      check("R2", int'(rsp_paddr), 40967);
      req_vaddr = 16'h2001; req_kind = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2", int'(rsp_paddr), 49153);
      check("R2", int'(rsp_fault), 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule